// File: doc/BRIEF.md
# Misused-ASI Double-FP Load Exception Classifier

This block decides which exception a double-precision floating-point alternate-space load must raise when its address-space identifier (ASI) is reserved for store-only use. Two groups of identifiers are reserved this way. The block-commit group holds 0xE0 and 0xE1. The partial-write group holds 0xC0 through 0xC5 and 0xC8 through 0xCD. For each request the block looks at the 8-bit ASI and the three low address bits. It returns a one-hot exception code and a fault-type field. The code and the field travel together as one registered result.

Alignment is checked before anything else. An address whose two lowest bits are not both zero raises the generic misaligned exception. An address that is 4-byte aligned but not 8-byte aligned raises the double-FP-load misaligned exception. Only when the address is 8-byte aligned does the ASI group decide the result. A block-commit ASI then raises a data access exception with fault type "invalid ASI". A partial-write ASI raises nothing. Any other ASI is outside the scope of this block, and the block reports "no exception" for it. The block makes no check on the destination register.

Requests enter and results leave through valid/ready handshakes. An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the next cycle on. The result stays unchanged until a cycle where `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-to-back requests therefore run at one per cycle with no bubble.

Top module: `misasi_classifier`

## Requirements
- R1: Case: block-commit ASI (0xE0 or 0xE1) with `in_addr[2:0]` = 000. Result: `out_exc` is 4'b0010 (data access exception) and `out_ftype` is 3'd3 (invalid ASI).
- R2: Case: block-commit or partial-write ASI with `in_addr[1:0]` = 00 and `in_addr[2]` = 1. Result: `out_exc` is 4'b0100 (double-FP-load misaligned) and `out_ftype` is 0.
- R3: Case: block-commit or partial-write ASI with `in_addr[1:0]` not 00. Result: `out_exc` is 4'b1000 (generic misaligned) and `out_ftype` is 0. This holds whatever the value of `in_addr[2]`.
- R4: Case: partial-write ASI (0xC0–0xC5 or 0xC8–0xCD) with `in_addr[2:0]` = 000. Result: `out_exc` is 4'b0001 (no exception) and `out_ftype` is 0.
- R5: Case: any ASI outside both groups, for example 0xC6, 0xC7, 0xCE, 0xBF or 0xE2. Result: `out_exc` is 4'b0001 and `out_ftype` is 0, for every address.
- R6: While `out_valid` is high, `out_exc` has exactly one bit set. `out_ftype` is non-zero only together with code 4'b0010.
- R7: An input beat accepted at a clock edge has its result on the outputs, with `out_valid` high, right after that edge. Back-to-back beats give back-to-back results.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_exc`/`out_ftype` hold their values. A beat offered with `in_valid` while `in_ready` is low is not taken.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request beat present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_asi | input | 8 | Address-space identifier of the load |
| in_addr | input | 3 | Low three bits of the load address |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_exc | output | 4 | One-hot exception: bit0 none, bit1 data access, bit2 double-FP misaligned, bit3 generic misaligned |
| out_ftype | output | 3 | Fault type; 3 = invalid ASI, 0 otherwise |

## Verification
All of the block's state sits in a single result register and its valid flag. A wrong decode or a wrong priority therefore shows up at the ports one cycle after the beat that exposes it. The sweep over every ASI with every alignment class is there so that a shifted range edge is caught on the first beat it touches. A wrong valid flag shows in the same cycle: either a stalled result changes value, or `in_ready` goes high while a result is still waiting.

// File: rtl/misasi_pkg.sv
package misasi_pkg;
  localparam int ASI_W   = 8;
  localparam int ALOW_W  = 3;
  localparam int EXC_W   = 4;
  localparam int FTYPE_W = 3;

  localparam logic [FTYPE_W-1:0] FT_NONE        = '0;
  localparam logic [FTYPE_W-1:0] FT_INVALID_ASI = 3'd3;

  // reserved ASI ranges; range 0 is the block-commit group
  localparam int NUM_RANGES = 3;
  localparam logic [ASI_W-1:0] RNG_LO [NUM_RANGES] = '{8'hE0, 8'hC0, 8'hC8};
  localparam logic [ASI_W-1:0] RNG_HI [NUM_RANGES] = '{8'hE1, 8'hC5, 8'hCD};
  localparam logic [NUM_RANGES-1:0] RNG_IS_BLK = 3'b001;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE      = 4'b0001,
    EXC_DACCESS   = 4'b0010,
    EXC_DFP_ALIGN = 4'b0100,
    EXC_ALIGN     = 4'b1000
  } exc_t;

  typedef enum logic [1:0] {
    AL_8     = 2'd0,
    AL_4     = 2'd1,
    AL_SMALL = 2'd2
  } align_t;

  typedef struct packed {
    exc_t               exc;
    logic [FTYPE_W-1:0] ftype;
  } verdict_t;
endpackage

// File: rtl/misasi_asi_match.sv
module misasi_asi_match
  import misasi_pkg::*;
(
  input  logic [ASI_W-1:0] asi,
  output logic             blk_hit,
  output logic             pst_hit
);
  logic [NUM_RANGES-1:0] hit;

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    assign hit[g] = (asi >= RNG_LO[g]) && (asi <= RNG_HI[g]);
  end

  assign blk_hit = |(hit & RNG_IS_BLK);
  assign pst_hit = |(hit & ~RNG_IS_BLK);
endmodule

// File: rtl/misasi_align_class.sv
module misasi_align_class
  import misasi_pkg::*;
(
  input  logic [ALOW_W-1:0] addr,
  output align_t            cls
);
  always_comb begin
    if (addr[1:0] != 2'b00) cls = AL_SMALL;
    else if (addr[2])       cls = AL_4;
    else                    cls = AL_8;
  end
endmodule

// File: rtl/misasi_prio.sv
module misasi_prio
  import misasi_pkg::*;
(
  input  logic     blk_hit,
  input  logic     pst_hit,
  input  align_t   cls,
  output verdict_t verdict
);
  always_comb begin
    verdict.exc   = EXC_NONE;
    verdict.ftype = FT_NONE;
    if (blk_hit || pst_hit) begin
      unique case (cls)
        AL_SMALL: verdict.exc = EXC_ALIGN;
        AL_4:     verdict.exc = EXC_DFP_ALIGN;
        default: begin
          if (blk_hit) begin
            verdict.exc   = EXC_DACCESS;
            verdict.ftype = FT_INVALID_ASI;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/misasi_out_stage.sv
module misasi_out_stage
  import misasi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     up_valid,
  output logic     up_ready,
  input  verdict_t up_data,
  output logic     dn_valid,
  input  logic     dn_ready,
  output verdict_t dn_data
);
  logic     vld_q;
  verdict_t data_q;

  assign up_ready = !vld_q || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '{exc: EXC_NONE, ftype: FT_NONE};
    end else if (up_ready) begin
      vld_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/misasi_classifier.sv
module misasi_classifier
  import misasi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ASI_W-1:0]   in_asi,
  input  logic [ALOW_W-1:0]  in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [EXC_W-1:0]   out_exc,
  output logic [FTYPE_W-1:0] out_ftype
);
  logic     blk_hit, pst_hit;
  align_t   cls;
  verdict_t verdict, held;

  misasi_asi_match u_match (
    .asi     (in_asi),
    .blk_hit (blk_hit),
    .pst_hit (pst_hit)
  );

  misasi_align_class u_align (
    .addr (in_addr),
    .cls  (cls)
  );

  misasi_prio u_prio (
    .blk_hit (blk_hit),
    .pst_hit (pst_hit),
    .cls     (cls),
    .verdict (verdict)
  );

  misasi_out_stage u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (verdict),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (held)
  );

  assign out_exc   = held.exc;
  assign out_ftype = held.ftype;
endmodule

// File: rtl/misasi_classifier_chk.sv
module misasi_classifier_chk
  import misasi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [ASI_W-1:0]   in_asi,
  input logic [ALOW_W-1:0]  in_addr,
  input logic               out_valid,
  input logic               out_ready,
  input logic [EXC_W-1:0]   out_exc,
  input logic [FTYPE_W-1:0] out_ftype
);
  logic take, rsv, is_blk;
  assign take   = in_valid && in_ready;
  assign is_blk = (in_asi == 8'hE0) || (in_asi == 8'hE1);
  assign rsv    = is_blk || (in_asi >= 8'hC0 && in_asi <= 8'hC5) ||
                  (in_asi >= 8'hC8 && in_asi <= 8'hCD);

  p_blk_invalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && is_blk && in_addr == 3'b000 |=> out_exc == 4'b0010 && out_ftype == 3'd3);

  p_dfp_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && rsv && in_addr[1:0] == 2'b00 && in_addr[2] |=> out_exc == 4'b0100);

  p_small_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && rsv && in_addr[1:0] != 2'b00 |=> out_exc == 4'b1000);

  p_outside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rsv |=> out_exc == 4'b0001 && out_ftype == 3'd0);

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_exc) == 1);

  p_ftype_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_exc != 4'b0010 |-> out_ftype == 3'd0);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_exc) && $stable(out_ftype));
endmodule

bind misasi_classifier misasi_classifier_chk u_chk (.*);

// File: tb/test_misasi_classifier.sv
module test_misasi_classifier;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_asi = '0;
  logic [2:0] in_addr = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_exc;
  logic [2:0] out_ftype;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  misasi_classifier i_misasi_classifier (.*);

  function automatic logic [3:0] exp_exc(input logic [7:0] a, input logic [2:0] ad);
    bit blk = (a == 8'hE0) || (a == 8'hE1);
    bit pst = (a >= 8'hC0 && a <= 8'hC5) || (a >= 8'hC8 && a <= 8'hCD);
    if (!blk && !pst)     return 4'b0001;
    if (ad[1:0] != 2'b00) return 4'b1000;
    if (ad[2])            return 4'b0100;
    if (blk)              return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [2:0] exp_ft(input logic [7:0] a, input logic [2:0] ad);
    return (exp_exc(a, ad) == 4'b0010) ? 3'd3 : 3'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one beat, result checked at the next negedge
  task automatic send_check(input string tag, input logic [7:0] a, input logic [2:0] ad);
    @(negedge clk);
    in_valid = 1'b1; in_asi = a; in_addr = ad; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " exc"}, {28'd0, out_exc}, {28'd0, exp_exc(a, ad)});
    check({tag, " ftype"}, {29'd0, out_ftype}, {29'd0, exp_ft(a, ad)});
  endtask

  task automatic t_reset_r9();
    @(negedge clk);
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_block_r1();
    send_check("R1 E0 aligned", 8'hE0, 3'b000);
    send_check("R1 E1 aligned", 8'hE1, 3'b000);
  endtask

  task automatic t_dfp_align_r2();
    send_check("R2 E0 addr4", 8'hE0, 3'b100);
    send_check("R2 C3 addr4", 8'hC3, 3'b100);
    send_check("R2 CD addr4", 8'hCD, 3'b100);
  endtask

  task automatic t_small_r3();
    send_check("R3 E1 addr2", 8'hE1, 3'b010);
    send_check("R3 E0 addr7", 8'hE0, 3'b111);
    send_check("R3 C8 addr1", 8'hC8, 3'b001);
    send_check("R3 C5 addr6", 8'hC5, 3'b110);
  endtask

  task automatic t_partial_r4();
    send_check("R4 C0 aligned", 8'hC0, 3'b000);
    send_check("R4 CD aligned", 8'hCD, 3'b000);
  endtask

  task automatic t_outside_r5();
    send_check("R5 C6", 8'hC6, 3'b000);
    send_check("R5 C7 addr1", 8'hC7, 3'b001);
    send_check("R5 CE addr4", 8'hCE, 3'b100);
    send_check("R5 BF", 8'hBF, 3'b000);
    send_check("R5 E2", 8'hE2, 3'b000);
    send_check("R5 DF", 8'hDF, 3'b010);
  endtask

  // every ASI against each alignment class; also R6 on every result
  task automatic t_sweep_r6();
    logic [2:0] addrs [4] = '{3'b000, 3'b100, 3'b010, 3'b001};
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 4; k++) begin
        send_check("R6 sweep", a[7:0], addrs[k]);
        check("R6 onehot", {31'd0, $countones(out_exc) == 1}, 32'd1);
      end
    end
  endtask

  task automatic t_stream_r7();
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_asi = 8'hE0; in_addr = 3'b000;
    @(negedge clk);
    check("R7 beat1 valid", {31'd0, out_valid}, 32'd1);
    check("R7 beat1 exc", {28'd0, out_exc}, 32'h2);
    in_asi = 8'hC1; in_addr = 3'b100;
    @(negedge clk);
    check("R7 beat2 valid", {31'd0, out_valid}, 32'd1);
    check("R7 beat2 exc", {28'd0, out_exc}, 32'h4);
    in_asi = 8'h10; in_addr = 3'b011;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 beat3 exc", {28'd0, out_exc}, 32'h1);
    @(negedge clk);
    check("R7 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_stall_r8();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_asi = 8'hE1; in_addr = 3'b000;
    @(negedge clk);
    in_asi = 8'hC2; in_addr = 3'b001; // offered while blocked
    for (int i = 0; i < 3; i++) begin
      check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R8 held exc", {28'd0, out_exc}, 32'h2);
      check("R8 held ftype", {29'd0, out_ftype}, 32'd3);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 blocked beat not taken", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    t_reset_r9();
    t_block_r1();
    t_dfp_align_r2();
    t_small_r3();
    t_partial_r4();
    t_outside_r5();
    t_stream_r7();
    t_stall_r8();
    t_sweep_r6();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule